// File: doc/BRIEF.md
# Configurable External Interrupt Pin Detector

This block watches a single external interrupt pin and turns activity on it into a sticky status flag and an optional interrupt request. The pin is sampled through a synchronizer. Four configuration bits, loaded together by a write strobe, set its behaviour:

- **pin enable** turns the detector on.
- **polarity** selects rising edges and high levels, or falling edges and low levels.
- **mode** selects edge-only detection, or detection of edges and levels.
- **interrupt enable** lets the flag raise a request. When it is clear, software can still poll the flag.

Software clears the flag with an acknowledge pulse. In level mode the flag keeps re-setting while the active level lasts, so the acknowledge has no lasting effect until the pin goes inactive. A separate combinational wake output is driven straight from the raw pin. It lets the pin wake the system while the clocks are stopped. For one cycle after any configuration write, detection is masked, so that a configuration change cannot be taken for a pin event.

Top module: `extint_detector`

## Requirements
- R1: While reset is high and after it, flag and irq are 0 and the configuration is cleared. With the pin disabled, wake is also 0.
- R2: With pin enable 0, no pin activity sets the flag and wake stays 0.
- R3: With polarity 1, a rising edge or a high level is active. With polarity 0, a falling edge or a low level is active.
- R4: In edge mode (mode bit 0), a change toward the active value between successive synchronized samples sets the flag. The flag shows this at the third rising clock edge after the pin changes. A steady active level does not set the flag again after it has been acknowledged.
- R5: In level mode (mode bit 1), the flag is set again on every clock while the synchronized pin is active, so an acknowledge clears it only once the pin is inactive.
- R6: irq equals flag AND interrupt enable. With interrupt enable 0, the flag still sets and irq stays 0 (poll only).
- R7: A one-cycle ack clears the flag on the next clock. If a new event occurs in the same cycle, the event wins and the flag stays 1.
- R8: In the cycle after a configuration write, no event is detected. Flipping the polarity while the pin is steady does not set the flag in edge mode.
- R9: wake is combinational: it is 1 exactly when stop is 1, pin enable is 1 and the raw pin equals the polarity bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 1 | Raw external interrupt pin |
| cfg_we | input | 1 | Loads the four configuration bits |
| cfg_pin_en | input | 1 | Pin enable value to load |
| cfg_act_high | input | 1 | Polarity value to load (1 = high/rising) |
| cfg_level_mode | input | 1 | Mode value to load (1 = edges and levels) |
| cfg_irq_en | input | 1 | Interrupt enable value to load |
| ack | input | 1 | Flag acknowledge pulse |
| stop_mode | input | 1 | System is in stop with clocks off |
| flag | output | 1 | Sticky event flag |
| irq | output | 1 | Interrupt request |
| wake | output | 1 | Asynchronous wake request |

## Verification
Directed sequences drive single edges of both polarities in both modes. They tell apart:

- edge and level sensing, through an acknowledge held against a steady active level;
- a correct synchronizer latency from an off-by-one latency, through the exact cycle in which the flag rises;
- event-over-acknowledge priority, through a collision cycle.

Polarity flips over a steady pin show whether the configuration mask and the edge comparison reject false edges. A long random stream of pin toggles, writes, acknowledges and stop requests is compared every cycle against a bench reference model, covering irq gating and the combinational wake path under mixed configurations.

// File: rtl/extint_pkg.sv
package extint_pkg;

    typedef struct packed {
        logic pin_en;
        logic act_high;
        logic level_mode;
        logic irq_en;
    } extint_cfg_t;

    localparam extint_cfg_t CFG_RESET = '{pin_en: 1'b0, act_high: 1'b0,
                                          level_mode: 1'b0, irq_en: 1'b0};

    // Map a pin sample onto "active" for the selected polarity.
    function automatic logic is_active(input logic sample, input logic act_high);
        return act_high ? sample : ~sample;
    endfunction

endpackage

// File: rtl/extint_sync.sv
module extint_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[0] <= 1'b0;
                    else     chain_q[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[i] <= 1'b0;
                    else     chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/extint_event.sv
module extint_event
    import extint_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        samp,
    input  extint_cfg_t cfg,
    input  logic        cfg_we,
    output logic        event_o
);
    logic prev_q;
    logic mask_q;
    logic act_now, act_prev, edge_hit, level_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            mask_q <= 1'b0;
        end else begin
            prev_q <= samp;
            mask_q <= cfg_we;
        end
    end

    always_comb begin
        act_now   = is_active(samp, cfg.act_high);
        act_prev  = is_active(prev_q, cfg.act_high);
        edge_hit  = act_now & ~act_prev;
        level_hit = act_now & cfg.level_mode;
        event_o   = cfg.pin_en & ~mask_q & (edge_hit | level_hit);
    end

    a_r2_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
        !cfg.pin_en |-> !event_o);
    a_r8_write_masks: assert property (@(posedge clk) disable iff (rst)
        cfg_we |=> !event_o);
    a_r5_level_holds: assert property (@(posedge clk) disable iff (rst)
        (cfg.pin_en && cfg.level_mode && !mask_q && act_now) |-> event_o);
    a_r4_no_event_inactive: assert property (@(posedge clk) disable iff (rst)
        !act_now |-> !event_o);
endmodule

// File: rtl/extint_flag.sv
module extint_flag
    import extint_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        event_i,
    input  logic        ack,
    input  extint_cfg_t cfg,
    output logic        flag,
    output logic        irq
);
    logic flag_q;

    always_ff @(posedge clk) begin
        if (rst)          flag_q <= 1'b0;
        else if (event_i) flag_q <= 1'b1;
        else if (ack)     flag_q <= 1'b0;
    end

    assign flag = flag_q;
    assign irq  = flag_q & cfg.irq_en;

    a_r7_event_wins: assert property (@(posedge clk) disable iff (rst)
        event_i |=> flag);
    a_r7_ack_clears: assert property (@(posedge clk) disable iff (rst)
        (ack && !event_i) |=> !flag);
    a_r6_poll_only: assert property (@(posedge clk) disable iff (rst)
        !cfg.irq_en |-> !irq);
    a_r4_sticky: assert property (@(posedge clk) disable iff (rst)
        (flag && !ack) |=> flag);
endmodule

// File: rtl/extint_wake.sv
module extint_wake
    import extint_pkg::*;
(
    input  logic        pin_in,
    input  logic        stop_mode,
    input  extint_cfg_t cfg,
    output logic        wake
);
    always_comb begin
        wake = stop_mode & cfg.pin_en & is_active(pin_in, cfg.act_high);
    end

    always_comb begin
        if (!stop_mode) a_r9_wake_only_in_stop: assert (!wake);
    end
endmodule

// File: rtl/extint_detector.sv
module extint_detector
    import extint_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_in,
    input  logic cfg_we,
    input  logic cfg_pin_en,
    input  logic cfg_act_high,
    input  logic cfg_level_mode,
    input  logic cfg_irq_en,
    input  logic ack,
    input  logic stop_mode,
    output logic flag,
    output logic irq,
    output logic wake
);
    extint_cfg_t cfg_q;
    logic        samp;
    logic        event_w;

    always_ff @(posedge clk) begin
        if (rst) cfg_q <= CFG_RESET;
        else if (cfg_we) cfg_q <= '{pin_en: cfg_pin_en, act_high: cfg_act_high,
                                    level_mode: cfg_level_mode, irq_en: cfg_irq_en};
    end

    extint_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d(pin_in), .q(samp)
    );

    extint_event u_event (
        .clk(clk), .rst(rst), .samp(samp), .cfg(cfg_q),
        .cfg_we(cfg_we), .event_o(event_w)
    );

    extint_flag u_flag (
        .clk(clk), .rst(rst), .event_i(event_w), .ack(ack),
        .cfg(cfg_q), .flag(flag), .irq(irq)
    );

    extint_wake u_wake (
        .pin_in(pin_in), .stop_mode(stop_mode), .cfg(cfg_q), .wake(wake)
    );

    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (!flag && !irq));
endmodule

// File: tb/test_extint_detector.sv
module test_extint_detector;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pin_in = 1'b0, cfg_we = 1'b0, ack = 1'b0, stop_mode = 1'b0;
    logic c_en = 1'b0, c_ah = 1'b0, c_lvl = 1'b0, c_irq = 1'b0;
    logic flag, irq, wake;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    // reference model state
    logic m_s1, m_s2, m_prev, m_mask, m_flag;
    logic m_en, m_ah, m_lvl, m_irq;

    always #4 clk = ~clk;

    extint_detector i_extint_detector (
        .clk(clk), .rst(rst), .pin_in(pin_in), .cfg_we(cfg_we),
        .cfg_pin_en(c_en), .cfg_act_high(c_ah), .cfg_level_mode(c_lvl),
        .cfg_irq_en(c_irq), .ack(ack), .stop_mode(stop_mode),
        .flag(flag), .irq(irq), .wake(wake)
    );

    function automatic logic act(input logic s, input logic ah);
        return ah ? s : ~s;
    endfunction

    task automatic check(input string tag, input logic got, input logic exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s got=%b exp=%b at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic model_edge();
        logic ev;
        if (rst) begin
            {m_s1, m_s2, m_prev, m_mask, m_flag} = '0;
            {m_en, m_ah, m_lvl, m_irq} = '0;
        end else begin
            ev = m_en & ~m_mask & act(m_s2, m_ah) &
                 (~act(m_prev, m_ah) | m_lvl);
            if (ev) m_flag = 1'b1;
            else if (ack) m_flag = 1'b0;
            m_prev = m_s2; m_s2 = m_s1; m_s1 = pin_in;
            m_mask = cfg_we;
            if (cfg_we) {m_en, m_ah, m_lvl, m_irq} = {c_en, c_ah, c_lvl, c_irq};
        end
    endtask

    // one clock; compare all outputs with the model at the next falling edge
    task automatic step(input string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check({tag, " flag"}, flag, m_flag);
        check("R6 irq", irq, m_flag & m_irq);
        check("R9 wake", wake, stop_mode & m_en & act(pin_in, m_ah));
        cfg_we = 1'b0;
        ack = 1'b0;
    endtask

    task automatic write_cfg(input logic en, input logic ah, input logic lvl,
                             input logic ie, input string tag);
        {c_en, c_ah, c_lvl, c_irq} = {en, ah, lvl, ie};
        cfg_we = 1'b1;
        step(tag);
    endtask

    task automatic run(input int n, input string tag);
        for (int i = 0; i < n; i++) step(tag);
    endtask

    initial begin
        #1600000;
        n_errors++;
        n_checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd7));
        rst = 1'b1;
        run(3, "R1");
        check("R1 reset flag", flag, 1'b0);
        check("R1 reset irq", irq, 1'b0);
        rst = 1'b0;
        stop_mode = 1'b1; pin_in = 1'b1;
        step("R1");
        check("R1 wake off after reset", wake, 1'b0);

        // R2: disabled pin ignores activity
        write_cfg(1'b0, 1'b1, 1'b1, 1'b1, "R2");
        for (int i = 0; i < 8; i++) begin pin_in = ~pin_in; step("R2"); end
        pin_in = 1'b1; run(4, "R2");
        check("R2 disabled flag", flag, 1'b0);
        check("R2 disabled wake", wake, 1'b0);
        stop_mode = 1'b0;

        // R3/R4: active-low edge, exact latency
        pin_in = 1'b1;
        write_cfg(1'b1, 1'b0, 1'b0, 1'b1, "R3");
        run(4, "R3");
        check("R3 no event while high", flag, 1'b0);
        pin_in = 1'b0;
        run(2, "R4");
        check("R4 not yet after two clocks", flag, 1'b0);
        step("R4");
        check("R4 flag at third clock", flag, 1'b1);
        check("R6 irq with enable", irq, 1'b1);
        ack = 1'b1; step("R4");
        check("R4 ack clears, steady level ignored", flag, 1'b0);
        run(4, "R4");
        check("R4 still clear", flag, 1'b0);

        // R8: polarity flip over steady pin
        write_cfg(1'b1, 1'b1, 1'b0, 1'b1, "R8");
        run(4, "R8");
        check("R8 no false edge on flip", flag, 1'b0);
        pin_in = 1'b1; run(4, "R3");
        check("R3 rising edge active high", flag, 1'b1);

        // R5: level mode, ack during active level
        write_cfg(1'b1, 1'b1, 1'b1, 1'b0, "R5");
        ack = 1'b1; step("R5");
        ack = 1'b1; step("R5");
        check("R5 ack ignored while level active", flag, 1'b1);
        check("R6 poll-only irq", irq, 1'b0);
        pin_in = 1'b0; run(3, "R5");
        ack = 1'b1; step("R5");
        check("R5 ack clears once inactive", flag, 1'b0);

        // R7: ack colliding with an edge event
        write_cfg(1'b1, 1'b1, 1'b0, 1'b1, "R7");
        pin_in = 1'b1; run(2, "R7");
        ack = 1'b1; step("R7");
        check("R7 event wins over ack", flag, 1'b1);
        ack = 1'b1; step("R7");
        check("R7 ack clears", flag, 1'b0);

        // R9: wake follows raw pin immediately
        stop_mode = 1'b1; pin_in = 1'b0; #1;
        check("R9 wake low", wake, 1'b0);
        pin_in = 1'b1; #1;
        check("R9 wake immediate", wake, 1'b1);
        step("R9");
        stop_mode = 1'b0;

        // random mixed traffic against the model
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 3) == 0) pin_in = ~pin_in;
            ack = ($urandom_range(0, 5) == 0);
            stop_mode = ($urandom_range(0, 3) == 0);
            if ($urandom_range(0, 15) == 0) begin
                {c_en, c_ah, c_lvl, c_irq} = 4'($urandom);
                cfg_we = 1'b1;
            end
            step("RND");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule